// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns single memory requests from an 8-bit core into bus cycles on a shared 8-bit address/data bus covering a 16-bit address space. A requester presents a request kind (code fetch, data read or data write), an address and, for writes, a data byte, then raises `req_start` for one clock while the block is idle. The block either answers the request at once, for a code fetch that falls inside on-chip code memory, or runs an external cycle. In an external cycle the low address byte goes out first with an address-latch pulse. The same bus is then used for data. The high address byte is held on its own port for the whole cycle.

Separate active-low strobes pick the space: one for code memory, one for data reads and one for data writes. A strap input says whether on-chip code memory is present. When the strap is low, or when the fetch address is above the on-chip limit (default 0FFFh), the fetch goes to the external bus. Data accesses always go to the external bus. The external address latch and memories lie outside this block.

Top module: `xbus_seq`

## Requirements
- R1: While reset is active and when idle, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `bus_oe` is 0, `bus_out` is FFh, and `req_done` and `code_int_hit` are 0.
- R2: A code fetch (`req_kind`=0) with `int_code_en`=1 and an address of at most CODE_TOP is served internally. `req_done` and `code_int_hit` are high together for exactly the one clock after the start clock, and there is no ALE, no strobe and no bus drive.
- R3: A code fetch with `int_code_en`=0, or with an address above CODE_TOP, runs an external cycle that uses `psen_n` as its strobe.
- R4: An external cycle begins on the clock after the start clock. `ale` is 1 for exactly that one clock. On the following clock `ale` is 0. In both clocks `bus_oe`=1 and `bus_out` carries address bits 7:0.
- R5: From the ALE clock through the final clock of the cycle, `addr_hi` equals address bits 15:8.
- R6: Starting on the third clock of the cycle, exactly one strobe is low for STRB_CYC clocks (default 2). The strobe is `psen_n` for kind 0, `rd_n` for kinds 1 and 3, and `wr_n` for kind 2. No strobe is ever low while `ale` is high.
- R7: For a read (kinds 0 external, 1 and 3), the bus is released (`bus_oe`=0, `bus_out`=FFh) from the first strobe clock through the end clock. `req_rdata` presents the `bus_in` value sampled on the last strobe clock.
- R8: For a write, `bus_oe`=1 and `bus_out` equals the write byte from the first strobe clock through the end clock, which is one clock after `wr_n` rises.
- R9: `req_done` is high for exactly one clock, the end clock, which follows the last strobe clock. Data accesses run externally whatever the values of `int_code_en` and the address.
- R10: A `req_start` that arrives while a cycle or an internal hit is in progress is ignored. The cycle in flight keeps its address, kind and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_kind | input | 2 | 0 code fetch, 1 data read, 2 data write, 3 data read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| int_code_en | input | 1 | Strap: on-chip code memory present |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 8 | Read result |
| code_int_hit | output | 1 | Fetch served internally |
| bus_out | output | 8 | Shared bus, driven value |
| bus_in | input | 8 | Shared bus, sampled value |
| bus_oe | output | 1 | Shared bus output enable |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Code memory strobe |
| rd_n | output | 1 | Data read strobe |
| wr_n | output | 1 | Data write strobe |

## Verification
The bench builds the block with its default parameters: a two-clock strobe and an on-chip code limit of 0FFFh. With these values both sides of the internal/external code boundary (0FFFh and 1000h) can be reached directly, and so can every address-high byte of the data space. The bench includes an external latch and a small data memory. Requests of every kind run back to back, and starts are held high during busy cycles to check that the block ignores them.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

  localparam logic [1:0] K_CODE = 2'd0;
  localparam logic [1:0] K_DRD  = 2'd1;
  localparam logic [1:0] K_DWR  = 2'd2;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_HIT  = 3'd1,
    PH_ADDR = 3'd2,
    PH_HOLD = 3'd3,
    PH_STRB = 3'd4,
    PH_END  = 3'd5
  } phase_e;

endpackage

// File: rtl/xbus_route.sv
`timescale 1ns/1ps
module xbus_route #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] CODE_TOP = 16'h0FFF
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              int_code_en,
  output logic              go_internal
);
  import xbus_pkg::*;

  logic is_code;
  logic in_window;

  always_comb begin
    is_code     = (kind == K_CODE);
    in_window   = (addr <= ADDR_W'(CODE_TOP));
    go_internal = is_code && int_code_en && in_window;
  end

endmodule

// File: rtl/xbus_phase_fsm.sv
`timescale 1ns/1ps
module xbus_phase_fsm #(
  parameter int STRB_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             go_internal,
  output xbus_pkg::phase_e phase,
  output logic             strb_last,
  output logic             accept
);
  import xbus_pkg::*;

  localparam int CW = (STRB_CYC < 2) ? 1 : $clog2(STRB_CYC);

  phase_e        ph_q, ph_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_en;

  always_comb begin
    accept    = (ph_q == PH_IDLE) && start;
    strb_last = (ph_q == PH_STRB) && (cnt_q == CW'(STRB_CYC - 1));
  end

  always_comb begin
    ph_nx = ph_q;
    unique case (ph_q)
      PH_IDLE: if (start) ph_nx = go_internal ? PH_HIT : PH_ADDR;
      PH_HIT:  ph_nx = PH_IDLE;
      PH_ADDR: ph_nx = PH_HOLD;
      PH_HOLD: ph_nx = PH_STRB;
      PH_STRB: if (strb_last) ph_nx = PH_END;
      PH_END:  ph_nx = PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_comb begin
    cnt_en = (ph_q == PH_STRB) || (cnt_q != '0);
    cnt_nx = ((ph_q == PH_STRB) && !strb_last) ? cnt_q + CW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nx;
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/xbus_pin_drv.sv
`timescale 1ns/1ps
module xbus_pin_drv #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [1:0]         kind_in,
  input  logic [ADDR_W-1:0]  addr_in,
  input  logic [DATA_W-1:0]  wdata_in,
  input  xbus_pkg::phase_e   phase,
  input  logic               strb_last,
  input  logic [DATA_W-1:0]  bus_in,
  output logic [DATA_W-1:0]  bus_out,
  output logic               bus_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic               ale,
  output logic               psen_n,
  output logic               rd_n,
  output logic               wr_n,
  output logic [DATA_W-1:0]  rdata,
  output logic               done,
  output logic               int_hit
);
  import xbus_pkg::*;

  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;
  logic              is_code, is_wr, is_rd;
  logic              in_addr, in_strb, in_data;
  logic              cap_en;

  always_comb begin
    is_code = (kind_q == K_CODE);
    is_wr   = (kind_q == K_DWR);
    is_rd   = !is_code && !is_wr;
    in_addr = (phase == PH_ADDR) || (phase == PH_HOLD);
    in_strb = (phase == PH_STRB);
    in_data = in_strb || (phase == PH_END);
    cap_en  = in_strb && strb_last && !is_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_CODE;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      kind_q <= kind_in;
      addr_q <= addr_in;
      wd_q   <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (cap_en) begin
      rd_q <= bus_in;
    end
  end

  always_comb begin
    if (in_addr) begin
      bus_out = addr_q[DATA_W-1:0];
      bus_oe  = 1'b1;
    end else if (in_data && is_wr) begin
      bus_out = wd_q;
      bus_oe  = 1'b1;
    end else begin
      bus_out = '1;
      bus_oe  = 1'b0;
    end
  end

  always_comb begin
    ale     = (phase == PH_ADDR);
    psen_n  = !(in_strb && is_code);
    rd_n    = !(in_strb && is_rd);
    wr_n    = !(in_strb && is_wr);
    addr_hi = addr_q[ADDR_W-1:DATA_W];
    done    = (phase == PH_END) || (phase == PH_HIT);
    int_hit = (phase == PH_HIT);
    rdata   = rd_q;
  end

endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          STRB_CYC = 2,
  parameter logic [15:0] CODE_TOP = 16'h0FFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_start,
  input  logic [1:0]                req_kind,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic                      int_code_en,
  output logic                      req_done,
  output logic [DATA_W-1:0]         req_rdata,
  output logic                      code_int_hit,
  output logic [DATA_W-1:0]         bus_out,
  input  logic [DATA_W-1:0]         bus_in,
  output logic                      bus_oe,
  output logic [ADDR_W-DATA_W-1:0]  addr_hi,
  output logic                      ale,
  output logic                      psen_n,
  output logic                      rd_n,
  output logic                      wr_n
);
  import xbus_pkg::*;

  logic   rst_s0, rst_sync_n;
  logic   go_int, strb_last, accept;
  phase_e phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  xbus_route #(.ADDR_W(ADDR_W), .CODE_TOP(CODE_TOP)) u_route (
    .kind        (req_kind),
    .addr        (req_addr),
    .int_code_en (int_code_en),
    .go_internal (go_int)
  );

  xbus_phase_fsm #(.STRB_CYC(STRB_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (req_start),
    .go_internal (go_int),
    .phase       (phase),
    .strb_last   (strb_last),
    .accept      (accept)
  );

  xbus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .kind_in   (req_kind),
    .addr_in   (req_addr),
    .wdata_in  (req_wdata),
    .phase     (phase),
    .strb_last (strb_last),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .addr_hi   (addr_hi),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rdata     (req_rdata),
    .done      (req_done),
    .int_hit   (code_int_hit)
  );

endmodule

// File: rtl/xbus_seq_chk.sv
`timescale 1ns/1ps
module xbus_seq_chk #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_out,
  input logic [HI_W-1:0]   addr_hi,
  input logic              done,
  input logic              int_hit
);

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  a_r6_no_strobe_in_ale: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));

  a_r4_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (bus_oe && $stable(bus_out)));

  a_r5_hi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n || !wr_n) |-> $stable(addr_hi));

  a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !bus_oe);

  a_r8_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (bus_oe && $stable(bus_out)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    int_hit |-> (done && !ale && !bus_oe && psen_n));

endmodule

bind xbus_seq xbus_seq_chk #(.DATA_W(DATA_W), .HI_W(ADDR_W-DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .ale     (ale),
  .psen_n  (psen_n),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .bus_oe  (bus_oe),
  .bus_out (bus_out),
  .addr_hi (addr_hi),
  .done    (req_done),
  .int_hit (code_int_hit)
);

// File: tb/sim_xbus_seq.sv
`timescale 1ns/1ps
module sim_xbus_seq;

  localparam int S = 2;

  logic        clk, rst_n;
  logic        req_start, int_code_en;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, bus_in;
  logic        req_done, code_int_hit, bus_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0]  req_rdata, bus_out, addr_hi;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // model state
  int          m_cnt = -1;
  bit          m_hit = 0;
  logic [1:0]  m_kind;
  logic [15:0] m_addr;
  logic [7:0]  m_wd, m_exp_rd;
  logic [7:0]  shadow [256];

  // external latch and memories
  logic [7:0]  lat_lo = 8'h00;
  logic [7:0]  dmem [256];

  function automatic logic [7:0] code_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always @(negedge ale) lat_lo = bus_out;
  always @(posedge wr_n) if (rst_n) dmem[lat_lo] = bus_out;
  assign bus_in = !rd_n   ? dmem[lat_lo] :
                  !psen_n ? code_fn({addr_hi, lat_lo}) : 8'hFF;

  xbus_seq #(.STRB_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .int_code_en(int_code_en),
    .req_done(req_done), .req_rdata(req_rdata), .code_int_hit(code_int_hit),
    .bus_out(bus_out), .bus_in(bus_in), .bus_oe(bus_oe), .addr_hi(addr_hi),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = -1;
      m_hit = 0;
    end else if (m_hit) begin
      m_hit = 0;
    end else if (m_cnt > 0) begin
      m_cnt = (m_cnt == 3 + S) ? -1 : m_cnt + 1;
    end else if (req_start) begin
      m_kind = req_kind;
      m_addr = req_addr;
      m_wd   = req_wdata;
      if (req_kind == 2'd0 && int_code_en && req_addr <= 16'h0FFF) begin
        m_hit = 1;
      end else begin
        m_cnt = 1;
        if (req_kind == 2'd2) shadow[req_addr[7:0]] = req_wdata;
        m_exp_rd = (req_kind == 2'd0) ? code_fn(req_addr) : shadow[req_addr[7:0]];
      end
    end
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit idle, strb, wr, cd, rd, adr;
      string tg;
      idle = (m_cnt < 0);
      strb = (m_cnt >= 3 && m_cnt <= 2 + S);
      adr  = (m_cnt == 1 || m_cnt == 2);
      wr   = !idle && m_kind == 2'd2;
      cd   = !idle && m_kind == 2'd0;
      rd   = !idle && !wr && !cd;
      tg   = (idle && !m_hit) ? "R1" : (m_hit ? "R2" : "R4");
      chk(tg, "ale", 16'(ale), 16'(m_cnt == 1));
      chk(adr ? "R4" : (wr ? "R8" : (tg == "R4" ? "R7" : tg)), "bus_oe",
          16'(bus_oe), 16'(adr || (wr && m_cnt >= 3)));
      chk(adr ? "R4" : (wr ? "R8" : (tg == "R4" ? "R7" : tg)), "bus_out",
          16'(bus_out), adr ? 16'(m_addr[7:0]) : ((wr && m_cnt >= 3) ? 16'(m_wd) : 16'hFF));
      chk(cd ? "R3" : "R6", "psen_n", 16'(psen_n), 16'(!(strb && cd)));
      chk(rd ? "R7" : "R6", "rd_n", 16'(rd_n), 16'(!(strb && rd)));
      chk(wr ? "R8" : "R6", "wr_n", 16'(wr_n), 16'(!(strb && wr)));
      chk(m_hit ? "R2" : "R9", "done", 16'(req_done), 16'(m_hit || m_cnt == 3 + S));
      chk("R2", "code_int_hit", 16'(code_int_hit), 16'(m_hit));
      if (!idle) chk("R5", "addr_hi", 16'(addr_hi), 16'(m_addr[15:8]));
      if (m_cnt == 3 + S && !wr) chk("R7", "req_rdata", 16'(req_rdata), 16'(m_exp_rd));
    end
  end

  task automatic do_req(input logic [1:0] k, input logic [15:0] a,
                        input logic [7:0] d, input logic en);
    req_kind = k; req_addr = a; req_wdata = d; int_code_en = en;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    while (m_cnt > 0 || m_hit) @(negedge clk);
  endtask

  initial begin
    int lf;
    for (int i = 0; i < 256; i++) begin
      dmem[i] = 8'h00;
      shadow[i] = 8'h00;
    end
    rst_n = 1'b0; req_start = 1'b0; req_kind = 2'd0;
    req_addr = 16'h0; req_wdata = 8'h0; int_code_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1 state held under reset
    chk("R1", "ale_rst", 16'(ale), 16'h0);
    chk("R1", "strobes_rst", 16'({psen_n, rd_n, wr_n}), 16'h7);
    chk("R1", "oe_rst", 16'(bus_oe), 16'h0);
    chk("R1", "done_rst", 16'(req_done), 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    do_req(2'd2, 16'h1234, 8'hA5, 1'b1);   // R8 write
    do_req(2'd2, 16'h8077, 8'h3C, 1'b1);   // R8 write, high data space
    do_req(2'd1, 16'h1234, 8'h00, 1'b1);   // R7 read back
    do_req(2'd0, 16'h0100, 8'h00, 1'b1);   // R2 internal
    do_req(2'd0, 16'h0FFF, 8'h00, 1'b1);   // R2 boundary internal
    do_req(2'd0, 16'h1000, 8'h00, 1'b1);   // R3 boundary external
    do_req(2'd0, 16'h0100, 8'h00, 1'b0);   // R3 strap low
    do_req(2'd3, 16'h8077, 8'h00, 1'b1);   // R6 kind 3 reads
    do_req(2'd1, 16'h0010, 8'h00, 1'b1);   // R9 data below limit still external

    // R10: start held high across a busy cycle with changing fields
    req_kind = 2'd2; req_addr = 16'h4455; req_wdata = 8'h99; req_start = 1'b1;
    @(negedge clk);
    req_kind = 2'd1; req_addr = 16'hABCD; req_wdata = 8'h11;
    repeat (3) @(negedge clk);
    req_start = 1'b0;
    while (m_cnt > 0 || m_hit) @(negedge clk);
    do_req(2'd1, 16'h0055, 8'h00, 1'b1);   // R10 only first write landed

    lf = 32'h1ACE5;
    for (int n = 0; n < 60; n++) begin
      logic [15:0] a;
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB4BCD35C : 0);
      a = lf[20] ? {4'h0, lf[11:0]} : lf[15:0];
      do_req(lf[17:16], a, lf[27:20], lf[19]);
      if (lf[22]) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule